// File: doc/BRIEF.md
# Timer Control and Status Register Block

This block holds the configuration word and the event-status word shared by three timer sources: a decrementer, a fixed-interval timer and a watchdog. Software writes the configuration word whole, using a one-cycle write strobe with a register select and a 32-bit data word. Software acknowledges events by writing ones to the status word. The timer engines raise status bits with one-cycle set pulses.

Each of the three interrupt outputs is a level. It stays high while its status bit and its enable bit are both 1. The block also decodes the configuration word into the period selectors, the watchdog reset-control field and the reload flag that the timer engines use. A resume input lets the system clear the watchdog status after a halt, and it does not disturb the other sources.

Top module: `tmr_ctlstat`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `ctrl_word` and `stat_word` are zero and all three interrupt outputs are low.
- R2: A write with `wr_sel`=0 stores all 32 bits of `wr_data` into the control word. The new value appears on `ctrl_word` one clock after the strobe, with no wait state.
- R3: The status word has these live bits: bit 31 (next-watchdog enable), bit 30 (watchdog event), bits 29:28 (watchdog reset state), bit 27 (decrementer event) and bit 26 (fixed-interval event). All other status bits always read 0. A write with `wr_sel`=1 clears every live bit that is 1 in `wr_data` and leaves the other bits unchanged.
- R4: Set pulses take effect one clock later: `set_dec` sets bit 27, `set_fit` sets bit 26, `set_wdg` sets bit 30, `set_enw` sets bit 31, and `set_wrs` is ORed into bits 29:28. A status bit stays set until it is cleared.
- R5: The interrupt outputs are `irq_dec` = status 27 AND control 26, `irq_wdg` = status 30 AND control 27, and `irq_fit` = status 26 AND control 23. They follow any register change in the same cycle that the new register value appears.
- R6: A `resume` pulse clears status bits 31:28 and leaves bits 27 and 26 and the control word unchanged.
- R7: When a set pulse meets a software clear or a resume clear on the same bit in the same cycle, the bit ends up set.
- R8: The decoded outputs are `wdg_period` = {control 20:17, control 31:30}, `fit_period` = {control 16:13, control 25:24}, `wdg_rst_ctl` = control 29:28 and `auto_reload` = control 22.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle register write strobe |
| wr_sel | input | 1 | Write target: 0 control word, 1 status word |
| wr_data | input | 32 | Write data |
| set_dec | input | 1 | Decrementer event pulse |
| set_fit | input | 1 | Fixed-interval event pulse |
| set_wdg | input | 1 | Watchdog event pulse |
| set_enw | input | 1 | Next-watchdog enable set pulse |
| set_wrs | input | 2 | Watchdog reset state bits to set |
| resume | input | 1 | Clear the watchdog status subset |
| ctrl_word | output | 32 | Current control word |
| stat_word | output | 32 | Current status word |
| irq_dec | output | 1 | Decrementer interrupt level |
| irq_fit | output | 1 | Fixed-interval interrupt level |
| irq_wdg | output | 1 | Watchdog interrupt level |
| wdg_period | output | 6 | Watchdog period selector |
| fit_period | output | 6 | Fixed-interval period selector |
| wdg_rst_ctl | output | 2 | Watchdog reset control field |
| auto_reload | output | 1 | Decrementer auto-reload enable |

## Verification
Each stimulus (a write, a set pulse or a resume) is latched at one rising edge. The register readback, the interrupt levels and the decoded fields are all due right after that same edge, because the interrupt levels and the decoded fields come combinationally from the registers. The bench drives every stimulus half a cycle before the edge that latches it and samples every output at the next falling edge, one register stage later. It compares the outputs there against a model that it updates only at the latching edge. The sweeps cover every pairing of the three enable bits with the three event bits, clear masks walked one bit at a time, and set pulses that coincide with clears and with resume.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

    localparam int unsigned WORD_W    = 32;
    localparam int unsigned BASE_W    = 2;
    localparam int unsigned EXT_W     = 4;
    localparam int unsigned PERIOD_W  = BASE_W + EXT_W;
    localparam int unsigned NUM_SRC   = 3;

    // control word bit positions (decoded by the timer engines)
    localparam int unsigned C_WP_LO   = 30;
    localparam int unsigned C_WRC_LO  = 28;
    localparam int unsigned C_WIE     = 27;
    localparam int unsigned C_DIE     = 26;
    localparam int unsigned C_FP_LO   = 24;
    localparam int unsigned C_FIE     = 23;
    localparam int unsigned C_ARE     = 22;
    localparam int unsigned C_WPX_LO  = 17;
    localparam int unsigned C_FPX_LO  = 13;

    // status word bit positions
    localparam int unsigned S_ENW     = 31;
    localparam int unsigned S_WIS     = 30;
    localparam int unsigned S_WRS_LO  = 28;
    localparam int unsigned S_DIS     = 27;
    localparam int unsigned S_FIS     = 26;

    typedef enum logic {
        SEL_CTRL = 1'b0,
        SEL_STAT = 1'b1
    } reg_sel_e;

    typedef enum int unsigned {
        SRC_DEC = 0,
        SRC_FIT = 1,
        SRC_WDG = 2
    } src_e;

    typedef struct packed {
        logic       enw;
        logic       wis;
        logic [1:0] wrs;
        logic       dis;
        logic       fis;
    } stat_t;

    typedef struct packed {
        logic [PERIOD_W-1:0] wdg_period;
        logic [PERIOD_W-1:0] fit_period;
        logic [1:0]          wdg_rst_ctl;
        logic                auto_reload;
        logic [NUM_SRC-1:0]  enables;
    } ctrl_fields_t;

    function automatic logic [WORD_W-1:0] stat_to_word(input stat_t s);
        logic [WORD_W-1:0] w;
        w                      = '0;
        w[S_ENW]               = s.enw;
        w[S_WIS]               = s.wis;
        w[S_WRS_LO+1:S_WRS_LO] = s.wrs;
        w[S_DIS]               = s.dis;
        w[S_FIS]               = s.fis;
        return w;
    endfunction

    function automatic stat_t word_to_stat(input logic [WORD_W-1:0] w);
        stat_t s;
        s.enw = w[S_ENW];
        s.wis = w[S_WIS];
        s.wrs = w[S_WRS_LO+1:S_WRS_LO];
        s.dis = w[S_DIS];
        s.fis = w[S_FIS];
        return s;
    endfunction

    function automatic stat_t resume_mask();
        stat_t s;
        s     = '0;
        s.enw = 1'b1;
        s.wis = 1'b1;
        s.wrs = 2'b11;
        return s;
    endfunction

endpackage

// File: rtl/tcs_ctrl_reg.sv
module tcs_ctrl_reg
    import tcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= din;
        end
    end

endmodule

// File: rtl/tcs_stat_reg.sv
module tcs_stat_reg
    import tcs_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  stat_t clr_mask,
    input  stat_t set_mask,
    output stat_t q
);

    stat_t nxt;

    // a set on the same cycle as a clear leaves the bit set
    always_comb begin
        nxt = (q & ~clr_mask) | set_mask;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= nxt;
        end
    end

endmodule

// File: rtl/tcs_field_decode.sv
module tcs_field_decode
    import tcs_pkg::*;
(
    input  logic [WORD_W-1:0] ctrl,
    output ctrl_fields_t      fields
);

    always_comb begin
        fields.wdg_period  = {ctrl[C_WPX_LO+EXT_W-1:C_WPX_LO],
                              ctrl[C_WP_LO+BASE_W-1:C_WP_LO]};
        fields.fit_period  = {ctrl[C_FPX_LO+EXT_W-1:C_FPX_LO],
                              ctrl[C_FP_LO+BASE_W-1:C_FP_LO]};
        fields.wdg_rst_ctl = ctrl[C_WRC_LO+1:C_WRC_LO];
        fields.auto_reload = ctrl[C_ARE];
        fields.enables                  = '0;
        fields.enables[int'(SRC_DEC)]   = ctrl[C_DIE];
        fields.enables[int'(SRC_FIT)]   = ctrl[C_FIE];
        fields.enables[int'(SRC_WDG)]   = ctrl[C_WIE];
    end

endmodule

// File: rtl/tcs_irq_gate.sv
module tcs_irq_gate
    import tcs_pkg::*;
(
    input  logic [NUM_SRC-1:0] pending,
    input  logic [NUM_SRC-1:0] enable,
    output logic [NUM_SRC-1:0] irq
);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign irq[g] = pending[g] & enable[g];
    end

endmodule

// File: rtl/tmr_ctlstat.sv
module tmr_ctlstat
    import tcs_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic                wr_sel,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic                set_dec,
    input  logic                set_fit,
    input  logic                set_wdg,
    input  logic                set_enw,
    input  logic [1:0]          set_wrs,
    input  logic                resume,
    output logic [WORD_W-1:0]   ctrl_word,
    output logic [WORD_W-1:0]   stat_word,
    output logic                irq_dec,
    output logic                irq_fit,
    output logic                irq_wdg,
    output logic [PERIOD_W-1:0] wdg_period,
    output logic [PERIOD_W-1:0] fit_period,
    output logic [1:0]          wdg_rst_ctl,
    output logic                auto_reload
);

    reg_sel_e           sel;
    logic               ctrl_load;
    logic               stat_wr;
    stat_t              clr_mask;
    stat_t              set_mask;
    stat_t              stat_q;
    ctrl_fields_t       fields;
    logic [NUM_SRC-1:0] pending;
    logic [NUM_SRC-1:0] irq_vec;

    assign sel       = reg_sel_e'(wr_sel);
    assign ctrl_load = wr_en && (sel == SEL_CTRL);
    assign stat_wr   = wr_en && (sel == SEL_STAT);

    always_comb begin
        clr_mask = '0;
        if (stat_wr) begin
            clr_mask = word_to_stat(wr_data);
        end
        if (resume) begin
            clr_mask = clr_mask | resume_mask();
        end
    end

    always_comb begin
        set_mask     = '0;
        set_mask.enw = set_enw;
        set_mask.wis = set_wdg;
        set_mask.wrs = set_wrs;
        set_mask.dis = set_dec;
        set_mask.fis = set_fit;
    end

    tcs_ctrl_reg u_ctrl (
        .clk  (clk),
        .rst  (rst),
        .load (ctrl_load),
        .din  (wr_data),
        .q    (ctrl_word)
    );

    tcs_stat_reg u_stat (
        .clk      (clk),
        .rst      (rst),
        .clr_mask (clr_mask),
        .set_mask (set_mask),
        .q        (stat_q)
    );

    tcs_field_decode u_dec (
        .ctrl   (ctrl_word),
        .fields (fields)
    );

    always_comb begin
        pending                 = '0;
        pending[int'(SRC_DEC)]  = stat_q.dis;
        pending[int'(SRC_FIT)]  = stat_q.fis;
        pending[int'(SRC_WDG)]  = stat_q.wis;
    end

    tcs_irq_gate u_irq (
        .pending (pending),
        .enable  (fields.enables),
        .irq     (irq_vec)
    );

    assign stat_word   = stat_to_word(stat_q);
    assign irq_dec     = irq_vec[int'(SRC_DEC)];
    assign irq_fit     = irq_vec[int'(SRC_FIT)];
    assign irq_wdg     = irq_vec[int'(SRC_WDG)];
    assign wdg_period  = fields.wdg_period;
    assign fit_period  = fields.fit_period;
    assign wdg_rst_ctl = fields.wdg_rst_ctl;
    assign auto_reload = fields.auto_reload;

endmodule

// File: rtl/tcs_checker.sv
module tcs_checker
    import tcs_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              wr_sel,
    input logic [WORD_W-1:0] wr_data,
    input logic              set_dec,
    input logic              set_fit,
    input logic              set_wdg,
    input logic              set_enw,
    input logic [1:0]        set_wrs,
    input logic              resume,
    input logic [WORD_W-1:0] ctrl_word,
    input logic [WORD_W-1:0] stat_word,
    input logic              irq_dec,
    input logic              irq_fit,
    input logic              irq_wdg
);

    localparam logic [WORD_W-1:0] LIVE = 32'hFC00_0000;

    logic any_set;
    assign any_set = set_dec | set_fit | set_wdg | set_enw | (|set_wrs);

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (ctrl_word == '0) && (stat_word == '0));

    a_r2_ctrl_load: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_sel) |=> ctrl_word == $past(wr_data));

    a_r3_w1c: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel && !any_set && !resume)
        |=> stat_word == ($past(stat_word) & ~($past(wr_data) & LIVE)));

    a_r3_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (stat_word & ~LIVE) == '0);

    a_r5_irq_dec: assert property (@(posedge clk) disable iff (rst)
        irq_dec == (stat_word[S_DIS] && ctrl_word[C_DIE]));

    a_r5_irq_fit: assert property (@(posedge clk) disable iff (rst)
        irq_fit == (stat_word[S_FIS] && ctrl_word[C_FIE]));

    a_r5_irq_wdg: assert property (@(posedge clk) disable iff (rst)
        irq_wdg == (stat_word[S_WIS] && ctrl_word[C_WIE]));

    a_r6_resume_subset: assert property (@(posedge clk) disable iff (rst)
        (resume && !wr_en && !any_set)
        |=> (stat_word[31:28] == 4'b0000)
            && (stat_word[27:26] == $past(stat_word[27:26])));

    a_r7_set_wins_dec: assert property (@(posedge clk) disable iff (rst)
        set_dec |=> stat_word[S_DIS]);

    a_r7_set_wins_wdg: assert property (@(posedge clk) disable iff (rst)
        set_wdg |=> stat_word[S_WIS]);

endmodule

bind tmr_ctlstat tcs_checker chk_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .set_dec   (set_dec),
    .set_fit   (set_fit),
    .set_wdg   (set_wdg),
    .set_enw   (set_enw),
    .set_wrs   (set_wrs),
    .resume    (resume),
    .ctrl_word (ctrl_word),
    .stat_word (stat_word),
    .irq_dec   (irq_dec),
    .irq_fit   (irq_fit),
    .irq_wdg   (irq_wdg)
);

// File: tb/tmr_ctlstat_tb_top.sv
module tmr_ctlstat_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic        wr_sel;
    logic [31:0] wr_data;
    logic        set_dec, set_fit, set_wdg, set_enw;
    logic [1:0]  set_wrs;
    logic        resume;
    logic [31:0] ctrl_word, stat_word;
    logic        irq_dec, irq_fit, irq_wdg;
    logic [5:0]  wdg_period, fit_period;
    logic [1:0]  wdg_rst_ctl;
    logic        auto_reload;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [31:0] m_ctrl;
    logic [31:0] m_stat;

    always #4 clk = ~clk;

    tmr_ctlstat dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .set_dec(set_dec), .set_fit(set_fit), .set_wdg(set_wdg), .set_enw(set_enw),
        .set_wrs(set_wrs), .resume(resume), .ctrl_word(ctrl_word),
        .stat_word(stat_word), .irq_dec(irq_dec), .irq_fit(irq_fit),
        .irq_wdg(irq_wdg), .wdg_period(wdg_period), .fit_period(fit_period),
        .wdg_rst_ctl(wdg_rst_ctl), .auto_reload(auto_reload)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        wr_en = 0; wr_sel = 0; wr_data = '0;
        set_dec = 0; set_fit = 0; set_wdg = 0; set_enw = 0; set_wrs = 2'b00;
        resume = 0;
    endtask

    // compare all outputs to the model; called at a falling edge
    task automatic check_all(input string tag);
        chk({tag, " R2 ctrl"}, ctrl_word, m_ctrl);
        chk({tag, " R3 stat"}, stat_word, m_stat);
        chk({tag, " R5 irq_dec"}, {31'b0, irq_dec}, {31'b0, m_stat[27] & m_ctrl[26]});
        chk({tag, " R5 irq_wdg"}, {31'b0, irq_wdg}, {31'b0, m_stat[30] & m_ctrl[27]});
        chk({tag, " R5 irq_fit"}, {31'b0, irq_fit}, {31'b0, m_stat[26] & m_ctrl[23]});
        chk({tag, " R8 wdg_period"}, {26'b0, wdg_period}, {26'b0, m_ctrl[20:17], m_ctrl[31:30]});
        chk({tag, " R8 fit_period"}, {26'b0, fit_period}, {26'b0, m_ctrl[16:13], m_ctrl[25:24]});
        chk({tag, " R8 rst_ctl"}, {30'b0, wdg_rst_ctl}, {30'b0, m_ctrl[29:28]});
        chk({tag, " R8 reload"}, {31'b0, auto_reload}, {31'b0, m_ctrl[22]});
    endtask

    // inputs already driven at a falling edge; latch at the rising edge
    task automatic step(input string tag);
        logic [31:0] clr, setm;
        clr  = '0;
        setm = '0;
        if (wr_en && wr_sel) clr = wr_data & 32'hFC00_0000;
        if (resume) clr = clr | 32'hF000_0000;
        setm[31] = set_enw; setm[30] = set_wdg; setm[29:28] = set_wrs;
        setm[27] = set_dec; setm[26] = set_fit;
        @(posedge clk);
        m_stat = (m_stat & ~clr) | setm;
        if (wr_en && !wr_sel) m_ctrl = wr_data;
        @(negedge clk);
        idle_inputs();
        check_all(tag);
    endtask

    task automatic wr(input logic sel, input logic [31:0] d, input string tag);
        wr_en = 1; wr_sel = sel; wr_data = d;
        step(tag);
    endtask

    logic [31:0] lfsr;

    initial begin
        idle_inputs();
        rst = 1;
        m_ctrl = '0;
        m_stat = '0;
        repeat (3) @(negedge clk);
        check_all("R1 during reset");
        rst = 0;
        @(negedge clk);
        check_all("R1 after reset");

        // R5 sweep: every enable combination against every event combination
        for (int e = 0; e < 8; e++) begin
            for (int s = 0; s < 8; s++) begin
                wr(1'b1, 32'hFFFF_FFFF, "R3 clear all");
                set_dec = s[0]; set_fit = s[1]; set_wdg = s[2];
                step("R4 set pulses");
                wr(1'b0, {4'b0, e[2], e[0], 2'b0, e[1], 23'b0}, "R5 enable sweep");
            end
        end

        // R3: walk one clear bit across the word with all status set
        for (int b = 0; b < 32; b++) begin
            set_dec = 1; set_fit = 1; set_wdg = 1; set_enw = 1; set_wrs = 2'b11;
            step("R4 set all");
            wr(1'b1, 32'h1 << b, "R3 walking clear");
        end

        // R4: wrs OR behaviour
        wr(1'b1, 32'hFFFF_FFFF, "R3 clear all");
        set_wrs = 2'b01; step("R4 wrs low");
        set_wrs = 2'b10; step("R4 wrs or");

        // R6: resume clears watchdog subset only
        set_dec = 1; set_fit = 1; set_wdg = 1; set_enw = 1;
        step("R4 set all");
        wr(1'b0, 32'h0C80_0000, "R2 enables on");
        resume = 1; step("R6 resume");
        chk("R6 dec/fit kept", stat_word, 32'h0C00_0000);

        // R7: set beats software clear and resume on the same bit
        wr_en = 1; wr_sel = 1; wr_data = 32'hFFFF_FFFF; set_dec = 1; set_wdg = 1;
        step("R7 set vs w1c");
        chk("R7 survivors", stat_word, 32'h4800_0000);
        resume = 1; set_enw = 1; set_wrs = 2'b10;
        step("R7 set vs resume");
        chk("R7 resume survivors", stat_word, 32'hA800_0000);

        // R8 and R2: pseudo-random control words
        lfsr = 32'hACE1_1234;
        for (int i = 0; i < 64; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            wr(1'b0, lfsr, "R8 field decode");
        end

        // R1: reset mid-run
        wr(1'b0, 32'hFFFF_FFFF, "R2 all ones");
        set_dec = 1; set_fit = 1; set_wdg = 1; step("R4 set");
        rst = 1;
        @(posedge clk);
        m_ctrl = '0; m_stat = '0;
        @(negedge clk);
        rst = 0;
        check_all("R1 reset mid-run");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule